// File: doc/BRIEF.md
# Counter Clock and Gate Routing Matrix

This block sits beside a bank of three-channel counter groups and decides, for every channel, what makes the channel count and what holds it off. Each channel has two 3-bit codes. The clock code picks one clock source. The choices are:

- the channel's own clock pin;
- one of five decade timebases derived from a 10 MHz reference enable;
- the output of the neighbouring channel;
- an external clock pin that all channels of a group share.

The selected clock is delivered as a single-cycle count-enable strobe. The gate code picks a constant level, the channel's own gate pin, or the inverted output of another channel. The resulting gate level is registered and sent to the counter core.

Groups are chained in a ring for both kinds of chaining, so the last group feeds the first. Whenever a channel does not listen to its own clock or gate pin, that pin is turned around. It then drives the channel's strobe or gate level outward. A readback port returns both codes of a selected channel and the period, in nanoseconds, of the timebase that the channel uses. The counter cores are outside the block: their outputs arrive here as inputs.

Top module: `ctr_route_matrix`

## Requirements
- R1: While reset is held, and after release until the first configuration write, every channel has clock code 0 and gate code 0. All count enables are 0, no clock pin is driven, every gate pin is driven, and the gate levels settle to 1.
- R2: A cycle with cfg_we high stores cfg_clk_sel and cfg_gate_sel into channel cfg_ch. Both codes are visible on rd_clk_sel and rd_gate_sel from the next cycle whenever rd_ch names that channel.
- R3: Clock codes 1 to 5 select the timebase that fires once every 10^(code-1) pulses of ref_tick, so code 1 fires on every pulse. The channel's count enable is high in the cycle after the timebase fires. With ref_tick held low, no such channel ever strobes.
- R4: Clock code 0 gives exactly one count-enable strobe for each rising edge of the channel's clock pin. The strobe appears in the third cycle after the pin is first seen high, and a pin held high gives no further strobes.
- R5: Clock code 6 counts on rising edges of a neighbour's output. Channel n>0 of a group uses channel n-1 of the same group. Channel 0 uses channel 2 of the preceding group, and the last group precedes group 0.
- R6: Clock code 7 counts on rising edges of the group's shared external clock, for every channel of that group and for no channel of any other group.
- R7: Gate code 0 gives gate level 1. Gate code 1 gives gate level 0, and so do the unused codes 4, 5, 6 and 7. The level follows one cycle after the code is stored.
- R8: Gate code 2 makes the gate level follow the channel's gate pin through a two-stage synchronizer plus one register, which is three cycles of latency.
- R9: Gate code 3 gives the inverse of another channel's output. Channel 2 of a group uses channel 0 of the same group. Channel n<2 uses channel n+1 of the preceding group, in the same ring.
- R10: clk_pin_oe of a channel is 1 exactly when its clock code is not 0. gate_pin_oe is 1 exactly when its gate code is not 2.
- R11: A driven clock pin carries the channel's count enable and a driven gate pin carries its gate level. A pin that is not driven has its output value at 0.
- R12: rd_period returns the timebase period in nanoseconds for the clock code on rd_clk_sel: 100, 1000, 10000, 100000 and 1000000 for codes 1 to 5, and 0 for codes 0, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | One-cycle enable at the 10 MHz reference rate |
| cfg_we | input | 1 | Store the codes for channel cfg_ch |
| cfg_ch | input | CH_W | Channel index to configure |
| cfg_clk_sel | input | 3 | Clock code to store |
| cfg_gate_sel | input | 3 | Gate code to store |
| rd_ch | input | CH_W | Channel index to read back |
| rd_clk_sel | output | 3 | Clock code of channel rd_ch |
| rd_gate_sel | output | 3 | Gate code of channel rd_ch |
| rd_period | output | 20 | Timebase period in ns for channel rd_ch |
| clk_pin_in | input | NUM_CH | Per-channel clock pin input |
| gate_pin_in | input | NUM_CH | Per-channel gate pin input |
| grp_ext_clk | input | NUM_GROUPS | Shared external clock of each group |
| ctr_out | input | NUM_CH | Outputs of the counter cores |
| cnt_en | output | NUM_CH | Count-enable strobe per channel |
| gate_lvl | output | NUM_CH | Gate level per channel |
| clk_pin_oe | output | NUM_CH | Clock pin is driven by the block |
| clk_pin_out | output | NUM_CH | Value driven on the clock pin |
| gate_pin_oe | output | NUM_CH | Gate pin is driven by the block |
| gate_pin_out | output | NUM_CH | Value driven on the gate pin |

## Verification
The bench goes after the ring wrap at group boundaries. It pulses one counter output at a time and checks that exactly one channel reacts. A design that wraps channel 0 or channel 1 to the wrong group would strobe or gate the wrong channel, or none at all. The timebase checks count strobes over windows that span whole periods, for codes 1, 2, 3 and 5. An off-by-one prescaler would give the wrong count, and a code-to-stage mix-up would give ten times too many or too few. Edge checks hold pins high to catch a level-sensitive enable, which would strobe on every cycle. The gate checks include the reserved codes and the sync latency, and would catch a design that leaves reserved gates open or skips a synchronizer stage.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;

  localparam int GRP_CH    = 3;
  localparam int SEL_W     = 3;
  localparam int PERIOD_W  = 20;
  localparam int N_DECADES = 5;

  typedef enum logic [SEL_W-1:0] {
    CS_PIN  = 3'd0,
    CS_10M  = 3'd1,
    CS_1M   = 3'd2,
    CS_100K = 3'd3,
    CS_10K  = 3'd4,
    CS_1K   = 3'd5,
    CS_PREV = 3'd6,
    CS_GRP  = 3'd7
  } clk_src_e;

  typedef enum logic [SEL_W-1:0] {
    GS_ON   = 3'd0,
    GS_OFF  = 3'd1,
    GS_PIN  = 3'd2,
    GS_NOUT = 3'd3,
    GS_RSV4 = 3'd4,
    GS_RSV5 = 3'd5,
    GS_RSV6 = 3'd6,
    GS_RSV7 = 3'd7
  } gate_src_e;

  // period of the decade timebase chosen by a clock code, 0 if none
  function automatic logic [PERIOD_W-1:0] tb_period_ns(input logic [SEL_W-1:0] code);
    logic [PERIOD_W-1:0] p;
    case (code)
      CS_10M:  p = 20'd100;
      CS_1M:   p = 20'd1000;
      CS_100K: p = 20'd10000;
      CS_10K:  p = 20'd100000;
      CS_1K:   p = 20'd1000000;
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ctr_decade_prescaler.sv
module ctr_decade_prescaler #(
  parameter int N_STAGES = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_tick,
  output logic [N_STAGES-1:0] tick
);

  // at_wrap[k]: stage k sits on its last count and passes the next tick on
  logic [N_STAGES-1:0] at_wrap;

  assign at_wrap[0] = 1'b1;

  always_comb begin
    tick[0] = ref_tick & at_wrap[0];
    for (int k = 1; k < N_STAGES; k++) begin
      tick[k] = tick[k-1] & at_wrap[k];
    end
  end

  for (genvar k = 1; k < N_STAGES; k++) begin : g_stage
    logic [3:0] cnt_q;
    logic [3:0] cnt_d;

    always_comb begin
      cnt_d = (cnt_q == 4'd9) ? 4'd0 : cnt_q + 4'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (tick[k-1]) begin
        cnt_q <= cnt_d;
      end
    end

    assign at_wrap[k] = (cnt_q == 4'd9);
  end

endmodule

// File: rtl/ctr_sync_bits.sv
module ctr_sync_bits #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;

endmodule

// File: rtl/ctr_rise_det.sv
module ctr_rise_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      lvl_q <= lvl;
    end
  end

  assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/ctr_route_chan.sv
module ctr_route_chan
  import ctr_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_clk_sel,
  input  logic [SEL_W-1:0]     wr_gate_sel,
  input  logic [N_DECADES-1:0] tb_tick,
  input  logic                 pin_rise,
  input  logic                 prev_rise,
  input  logic                 grp_rise,
  input  logic                 gate_pin_lvl,
  input  logic                 nout_lvl,
  output logic [SEL_W-1:0]     clk_sel,
  output logic [SEL_W-1:0]     gate_sel,
  output logic                 cnt_en,
  output logic                 gate_lvl
);

  clk_src_e  csel_q, csel_d;
  gate_src_e gsel_q, gsel_d;
  logic      en_q,   en_d;
  logic      gate_q, gate_d;

  always_comb begin
    csel_d = csel_q;
    gsel_d = gsel_q;
    if (wr_en) begin
      csel_d = clk_src_e'(wr_clk_sel);
      gsel_d = gate_src_e'(wr_gate_sel);
    end
  end

  always_comb begin
    case (csel_q)
      CS_PIN:  en_d = pin_rise;
      CS_10M:  en_d = tb_tick[0];
      CS_1M:   en_d = tb_tick[1];
      CS_100K: en_d = tb_tick[2];
      CS_10K:  en_d = tb_tick[3];
      CS_1K:   en_d = tb_tick[4];
      CS_PREV: en_d = prev_rise;
      CS_GRP:  en_d = grp_rise;
      default: en_d = 1'b0;
    endcase
  end

  always_comb begin
    case (gsel_q)
      GS_ON:   gate_d = 1'b1;
      GS_OFF:  gate_d = 1'b0;
      GS_PIN:  gate_d = gate_pin_lvl;
      GS_NOUT: gate_d = ~nout_lvl;
      default: gate_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q <= CS_PIN;
      gsel_q <= GS_ON;
      en_q   <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      csel_q <= csel_d;
      gsel_q <= gsel_d;
      en_q   <= en_d;
      gate_q <= gate_d;
    end
  end

  assign clk_sel  = csel_q;
  assign gate_sel = gsel_q;
  assign cnt_en   = en_q;
  assign gate_lvl = gate_q;

endmodule

// File: rtl/ctr_route_matrix.sv
module ctr_route_matrix
  import ctr_route_pkg::*;
#(
  parameter int  NUM_GROUPS = 2,
  localparam int NUM_CH     = NUM_GROUPS * GRP_CH,
  localparam int CH_W       = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_tick,
  input  logic                cfg_we,
  input  logic [CH_W-1:0]     cfg_ch,
  input  logic [SEL_W-1:0]    cfg_clk_sel,
  input  logic [SEL_W-1:0]    cfg_gate_sel,
  input  logic [CH_W-1:0]     rd_ch,
  output logic [SEL_W-1:0]    rd_clk_sel,
  output logic [SEL_W-1:0]    rd_gate_sel,
  output logic [PERIOD_W-1:0] rd_period,
  input  logic [NUM_CH-1:0]   clk_pin_in,
  input  logic [NUM_CH-1:0]   gate_pin_in,
  input  logic [NUM_GROUPS-1:0] grp_ext_clk,
  input  logic [NUM_CH-1:0]   ctr_out,
  output logic [NUM_CH-1:0]   cnt_en,
  output logic [NUM_CH-1:0]   gate_lvl,
  output logic [NUM_CH-1:0]   clk_pin_oe,
  output logic [NUM_CH-1:0]   clk_pin_out,
  output logic [NUM_CH-1:0]   gate_pin_oe,
  output logic [NUM_CH-1:0]   gate_pin_out
);

  // reset: asserted at once, released through two flops
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // timebases
  logic [N_DECADES-1:0] tb_tick;

  ctr_decade_prescaler #(.N_STAGES(N_DECADES)) i_presc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ref_tick (ref_tick),
    .tick     (tb_tick)
  );

  // synchronizers and edge detectors
  logic [NUM_CH-1:0]     clk_pin_lvl, clk_pin_rise;
  logic [NUM_CH-1:0]     gate_pin_lvl;
  logic [NUM_CH-1:0]     out_lvl, out_rise;
  logic [NUM_GROUPS-1:0] grp_lvl, grp_rise;

  ctr_sync_bits #(.W(NUM_CH)) i_sync_cpin (
    .clk(clk), .rst_n(rst_sync_n), .din(clk_pin_in), .dout(clk_pin_lvl));
  ctr_rise_det  #(.W(NUM_CH)) i_rise_cpin (
    .clk(clk), .rst_n(rst_sync_n), .lvl(clk_pin_lvl), .rise(clk_pin_rise));

  ctr_sync_bits #(.W(NUM_CH)) i_sync_gpin (
    .clk(clk), .rst_n(rst_sync_n), .din(gate_pin_in), .dout(gate_pin_lvl));

  ctr_sync_bits #(.W(NUM_CH)) i_sync_out (
    .clk(clk), .rst_n(rst_sync_n), .din(ctr_out), .dout(out_lvl));
  ctr_rise_det  #(.W(NUM_CH)) i_rise_out (
    .clk(clk), .rst_n(rst_sync_n), .lvl(out_lvl), .rise(out_rise));

  ctr_sync_bits #(.W(NUM_GROUPS)) i_sync_grp (
    .clk(clk), .rst_n(rst_sync_n), .din(grp_ext_clk), .dout(grp_lvl));
  ctr_rise_det  #(.W(NUM_GROUPS)) i_rise_grp (
    .clk(clk), .rst_n(rst_sync_n), .lvl(grp_lvl), .rise(grp_rise));

  // channels with their ring connections
  logic [SEL_W-1:0] ch_clk_sel  [NUM_CH];
  logic [SEL_W-1:0] ch_gate_sel [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP  = c / GRP_CH;
    localparam int POS  = c % GRP_CH;
    localparam int PGRP = (GRP + NUM_GROUPS - 1) % NUM_GROUPS;
    localparam int CSRC = (POS > 0) ? c - 1 : PGRP * GRP_CH + 2;
    localparam int GSRC = (POS == 2) ? GRP * GRP_CH : PGRP * GRP_CH + POS + 1;

    logic wr_hit;
    assign wr_hit = cfg_we && (cfg_ch == CH_W'(c));

    ctr_route_chan i_chan (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .wr_en        (wr_hit),
      .wr_clk_sel   (cfg_clk_sel),
      .wr_gate_sel  (cfg_gate_sel),
      .tb_tick      (tb_tick),
      .pin_rise     (clk_pin_rise[c]),
      .prev_rise    (out_rise[CSRC]),
      .grp_rise     (grp_rise[GRP]),
      .gate_pin_lvl (gate_pin_lvl[c]),
      .nout_lvl     (out_lvl[GSRC]),
      .clk_sel      (ch_clk_sel[c]),
      .gate_sel     (ch_gate_sel[c]),
      .cnt_en       (cnt_en[c]),
      .gate_lvl     (gate_lvl[c])
    );

    assign clk_pin_oe[c]   = (ch_clk_sel[c] != CS_PIN);
    assign gate_pin_oe[c]  = (ch_gate_sel[c] != GS_PIN);
    assign clk_pin_out[c]  = clk_pin_oe[c] & cnt_en[c];
    assign gate_pin_out[c] = gate_pin_oe[c] & gate_lvl[c];
  end

  // readback
  always_comb begin
    rd_clk_sel  = '0;
    rd_gate_sel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ch == CH_W'(i)) begin
        rd_clk_sel  = ch_clk_sel[i];
        rd_gate_sel = ch_gate_sel[i];
      end
    end
  end

  assign rd_period = tb_period_ns(rd_clk_sel);

endmodule

// File: rtl/ctr_route_matrix_chk.sv
module ctr_route_matrix_chk
  import ctr_route_pkg::*;
#(
  parameter int  NUM_GROUPS = 2,
  localparam int NUM_CH     = NUM_GROUPS * GRP_CH,
  localparam int CH_W       = $clog2(NUM_CH)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rst_ok,
  input logic                ref_tick,
  input logic [CH_W-1:0]     rd_ch,
  input logic [SEL_W-1:0]    rd_clk_sel,
  input logic [SEL_W-1:0]    rd_gate_sel,
  input logic [PERIOD_W-1:0] rd_period,
  input logic [NUM_CH-1:0]   cnt_en,
  input logic [NUM_CH-1:0]   gate_lvl,
  input logic [NUM_CH-1:0]   clk_pin_oe,
  input logic [NUM_CH-1:0]   clk_pin_out,
  input logic [NUM_CH-1:0]   gate_pin_oe,
  input logic [NUM_CH-1:0]   gate_pin_out
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (cnt_en == '0 && clk_pin_oe == '0));

  a_r12_period_code: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_period != '0) |-> (rd_clk_sel >= 3'd1 && rd_clk_sel <= 3'd5));

  a_r12_period_fast: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_clk_sel == 3'd1) |-> (rd_period == 20'd100));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r10_clk_oe: assert property (@(posedge clk) disable iff (!rst_ok)
      (rd_ch == CH_W'(i)) |-> (clk_pin_oe[i] == (rd_clk_sel != 3'd0)));

    a_r10_gate_oe: assert property (@(posedge clk) disable iff (!rst_ok)
      (rd_ch == CH_W'(i)) |-> (gate_pin_oe[i] == (rd_gate_sel != 3'd2)));

    a_r11_clk_drive: assert property (@(posedge clk) disable iff (!rst_ok)
      clk_pin_oe[i] |-> (clk_pin_out[i] == cnt_en[i]));

    a_r11_gate_drive: assert property (@(posedge clk) disable iff (!rst_ok)
      gate_pin_oe[i] |-> (gate_pin_out[i] == gate_lvl[i]));

    a_r7_gate_on: assert property (@(posedge clk) disable iff (!rst_ok)
      $past(rst_ok && rd_ch == CH_W'(i) && rd_gate_sel == 3'd0) |-> gate_lvl[i]);

    a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_ok)
      $past(rst_ok && rd_ch == CH_W'(i) && rd_gate_sel != 3'd0 &&
            rd_gate_sel != 3'd2 && rd_gate_sel != 3'd3) |-> !gate_lvl[i]);

    a_r3_no_ref_no_count: assert property (@(posedge clk) disable iff (!rst_ok)
      $past(rst_ok && rd_ch == CH_W'(i) && !ref_tick &&
            rd_clk_sel >= 3'd1 && rd_clk_sel <= 3'd5) |-> !cnt_en[i]);
  end

endmodule

bind ctr_route_matrix ctr_route_matrix_chk #(.NUM_GROUPS(NUM_GROUPS)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_ok       (rst_sync_n),
  .ref_tick     (ref_tick),
  .rd_ch        (rd_ch),
  .rd_clk_sel   (rd_clk_sel),
  .rd_gate_sel  (rd_gate_sel),
  .rd_period    (rd_period),
  .cnt_en       (cnt_en),
  .gate_lvl     (gate_lvl),
  .clk_pin_oe   (clk_pin_oe),
  .clk_pin_out  (clk_pin_out),
  .gate_pin_oe  (gate_pin_oe),
  .gate_pin_out (gate_pin_out)
);

// File: tb/test_ctr_route_matrix.sv
module test_ctr_route_matrix;

  localparam int NG = 2;
  localparam int NC = NG * 3;
  localparam int CW = $clog2(NC);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_tick = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_ch = '0;
  logic [2:0]    cfg_clk_sel = '0;
  logic [2:0]    cfg_gate_sel = '0;
  logic [CW-1:0] rd_ch = '0;
  logic [2:0]    rd_clk_sel, rd_gate_sel;
  logic [19:0]   rd_period;
  logic [NC-1:0] clk_pin_in = '0;
  logic [NC-1:0] gate_pin_in = '0;
  logic [NG-1:0] grp_ext_clk = '0;
  logic [NC-1:0] ctr_out = '0;
  logic [NC-1:0] cnt_en, gate_lvl, clk_pin_oe, clk_pin_out, gate_pin_oe, gate_pin_out;

  int n_chk = 0;
  int n_bad = 0;
  int acc [NC];
  logic cnt_on = 1'b0;
  int ref_mode = 0; // 0 off, 1 every cycle, 2 every other cycle
  logic ref_phase = 1'b0;

  always #10 clk = ~clk;

  ctr_route_matrix #(.NUM_GROUPS(NG)) i_ctr_route_matrix (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_clk_sel(cfg_clk_sel), .cfg_gate_sel(cfg_gate_sel),
    .rd_ch(rd_ch), .rd_clk_sel(rd_clk_sel), .rd_gate_sel(rd_gate_sel), .rd_period(rd_period),
    .clk_pin_in(clk_pin_in), .gate_pin_in(gate_pin_in), .grp_ext_clk(grp_ext_clk),
    .ctr_out(ctr_out), .cnt_en(cnt_en), .gate_lvl(gate_lvl),
    .clk_pin_oe(clk_pin_oe), .clk_pin_out(clk_pin_out),
    .gate_pin_oe(gate_pin_oe), .gate_pin_out(gate_pin_out)
  );

  // strobe counting and reference drive, both at the falling edge
  always @(negedge clk) begin
    if (cnt_on) begin
      for (int i = 0; i < NC; i++) if (cnt_en[i]) acc[i]++;
    end
    ref_phase <= ~ref_phase;
    case (ref_mode)
      1:       ref_tick <= 1'b1;
      2:       ref_tick <= ref_phase;
      default: ref_tick <= 1'b0;
    endcase
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input int cs, input int gs);
    cfg_ch = CW'(ch); cfg_clk_sel = 3'(cs); cfg_gate_sel = 3'(gs); cfg_we = 1'b1;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic wr_all(input int cs, input int gs);
    for (int c = 0; c < NC; c++) wr(c, cs, gs);
  endtask

  task automatic clr_acc();
    for (int i = 0; i < NC; i++) acc[i] = 0;
  endtask

  function automatic int prev_grp(input int c);
    return (c / 3 + NG - 1) % NG;
  endfunction

  function automatic int clk_chain_src(input int c);
    return (c % 3 > 0) ? c - 1 : prev_grp(c) * 3 + 2;
  endfunction

  function automatic int gate_chain_src(input int c);
    return (c % 3 == 2) ? (c / 3) * 3 : prev_grp(c) * 3 + (c % 3) + 1;
  endfunction

  task automatic t_reset();
    cyc(4);
    chk("R1 cnt_en", 32'(cnt_en), 32'h0);
    chk("R1 clk_pin_oe", 32'(clk_pin_oe), 32'h0);
    chk("R1 gate_pin_oe", 32'(gate_pin_oe), 32'h3F);
    chk("R1 gate_lvl", 32'(gate_lvl), 32'h3F);
    for (int c = 0; c < NC; c++) begin
      rd_ch = CW'(c); #1;
      chk("R1 clk code", 32'(rd_clk_sel), 32'h0);
      chk("R1 gate code", 32'(rd_gate_sel), 32'h0);
    end
    rd_ch = '0;
  endtask

  task automatic t_cfg_period();
    for (int k = 0; k < 8; k++) begin
      wr(4, k, 7 - k);
      rd_ch = CW'(4); #1;
      chk("R2 clk code", 32'(rd_clk_sel), 32'(k));
      chk("R2 gate code", 32'(rd_gate_sel), 32'(7 - k));
      if (k >= 1 && k <= 5) chk("R12 period", 32'(rd_period), 32'(100 * (10 ** (k - 1))));
      else chk("R12 period zero", 32'(rd_period), 32'h0);
    end
    rd_ch = CW'(3); #1;
    chk("R2 other channel untouched", 32'(rd_clk_sel), 32'h0);
    wr(4, 0, 0);
  endtask

  task automatic t_timebase();
    wr(0, 2, 0); wr(1, 3, 0);
    ref_mode = 1; cyc(6);
    clr_acc(); cnt_on = 1'b1; cyc(1000); cnt_on = 1'b0;
    chk("R3 code2 per 1000", 32'(acc[0]), 32'd100);
    chk("R3 code3 per 1000", 32'(acc[1]), 32'd10);
    wr(1, 5, 0); cyc(4);
    clr_acc(); cnt_on = 1'b1; cyc(20000); cnt_on = 1'b0;
    chk("R3 code5 per 20000", 32'(acc[1]), 32'd2);
    wr(2, 1, 0);
    ref_mode = 2; cyc(6);
    clr_acc(); cnt_on = 1'b1; cyc(200); cnt_on = 1'b0;
    chk("R3 code1 alternate ref", 32'(acc[2]), 32'd100);
    ref_mode = 0; cyc(4);
    clr_acc(); cnt_on = 1'b1; cyc(300); cnt_on = 1'b0;
    chk("R3 no ref no strobe", 32'(acc[0] + acc[1] + acc[2]), 32'd0);
    wr(0, 0, 0); wr(1, 0, 0); wr(2, 0, 0);
  endtask

  task automatic t_own_pin();
    cyc(4);
    clk_pin_in[0] = 1'b1;
    cyc(2); chk("R4 no strobe before sync", 32'(cnt_en[0]), 32'h0);
    cyc(1); chk("R4 strobe third cycle", 32'(cnt_en[0]), 32'h1);
    cyc(1); chk("R4 single cycle strobe", 32'(cnt_en[0]), 32'h0);
    clr_acc(); cnt_on = 1'b1; cyc(20);
    chk("R4 held pin no more strobes", 32'(acc[0]), 32'd0);
    clk_pin_in[0] = 1'b0; cyc(3);
    for (int p = 0; p < 5; p++) begin
      clk_pin_in[0] = 1'b1; cyc(3); clk_pin_in[0] = 1'b0; cyc(3);
    end
    cyc(4); cnt_on = 1'b0;
    chk("R4 five edges", 32'(acc[0]), 32'd5);
  endtask

  task automatic t_clk_chain();
    wr_all(6, 0); cyc(4);
    for (int j = 0; j < NC; j++) begin
      clr_acc(); cnt_on = 1'b1;
      ctr_out[j] = 1'b1; cyc(3); ctr_out[j] = 1'b0; cyc(6);
      cnt_on = 1'b0;
      for (int c = 0; c < NC; c++)
        chk($sformatf("R5 out%0d to ch%0d", j, c), 32'(acc[c]), 32'((clk_chain_src(c) == j) ? 1 : 0));
    end
  endtask

  task automatic t_grp_clk();
    wr_all(7, 0); cyc(4);
    clr_acc(); cnt_on = 1'b1;
    for (int p = 0; p < 4; p++) begin
      grp_ext_clk[1] = 1'b1; cyc(3); grp_ext_clk[1] = 1'b0; cyc(3);
    end
    cyc(4); cnt_on = 1'b0;
    for (int c = 0; c < NC; c++)
      chk($sformatf("R6 ch%0d", c), 32'(acc[c]), 32'((c / 3 == 1) ? 4 : 0));
  endtask

  task automatic t_gate_const();
    wr(0, 0, 0); wr(1, 0, 1); wr(2, 0, 4); wr(3, 0, 5); wr(4, 0, 6); wr(5, 0, 7);
    cyc(1);
    chk("R7 gate codes 0 1 4..7", 32'(gate_lvl), 32'h01);
    wr(5, 0, 0); cyc(1);
    chk("R7 gate on after rewrite", 32'(gate_lvl[5]), 32'h1);
  endtask

  task automatic t_gate_pin();
    wr(3, 0, 2); gate_pin_in[3] = 1'b1; cyc(2);
    chk("R8 not yet through sync", 32'(gate_lvl[3]), 32'h0);
    cyc(1);
    chk("R8 gate pin high", 32'(gate_lvl[3]), 32'h1);
    gate_pin_in[3] = 1'b0; cyc(3);
    chk("R8 gate pin low", 32'(gate_lvl[3]), 32'h0);
    chk("R10 gate pin input", 32'(gate_pin_oe[3]), 32'h0);
    chk("R11 undriven gate pin", 32'(gate_pin_out[3]), 32'h0);
  endtask

  task automatic t_gate_chain();
    wr_all(0, 3); cyc(4);
    chk("R9 all outputs low", 32'(gate_lvl), 32'h3F);
    for (int j = 0; j < NC; j++) begin
      logic [NC-1:0] exp;
      ctr_out = NC'(1) << j; cyc(4);
      for (int c = 0; c < NC; c++) exp[c] = ~ctr_out[gate_chain_src(c)];
      chk($sformatf("R9 out%0d high", j), 32'(gate_lvl), 32'(exp));
    end
    ctr_out = '0; cyc(4);
  endtask

  task automatic t_pins();
    wr(2, 1, 0); wr(0, 0, 1); wr(1, 0, 2);
    ref_mode = 1; cyc(5);
    chk("R10 clk oe", 32'(clk_pin_oe), 32'h04);
    chk("R11 clk pin follows strobe", 32'(clk_pin_out), 32'h04);
    chk("R10 gate oe", 32'(gate_pin_oe[2:0]), 32'h5);
    chk("R11 gate pin values", 32'(gate_pin_out[2:0]), 32'h4);
    ref_mode = 0; cyc(3);
    chk("R11 clk pin idle", 32'(clk_pin_out), 32'h0);
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    clr_acc();
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_cfg_period();
    t_timebase();
    t_own_pin();
    t_clk_chain();
    t_grp_clk();
    t_gate_const();
    t_gate_pin();
    t_gate_chain();
    t_pins();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule